// File: doc/BRIEF.md
# Double-Buffered 16-Bit Compare Channel

This block is the compare stage of one channel of a 16-bit timer. Software reaches it over a byte-wide register port. A compare value is written as two bytes: the upper byte first goes into a shared staging byte, and a later write of the lower byte commits all sixteen bits in a single clock. Where the committed value lands depends on the selected waveform mode. In the two PWM modes it lands in a shadow buffer. That buffer is moved into the live compare register only when the counter reports the update event the mode calls for (TOP or BOTTOM). This prevents a pulse of odd length or odd shape. In the non-PWM modes the write goes straight to the live register.

Each clock, a 16-bit equality test runs between the live register and the counter value supplied from outside. A hit sets a sticky match flag. Software clears the flag by writing a one to it. The counter, the waveform output logic and the interrupt logic all sit outside this block. Only the timer's strobes, the count and the mode enter as inputs.

Top module: `cmp16_dbuf`

## Requirements
- R1: After reset, `cmp_value` is 0, `match_flag` is 0, `rd_data` is 0, and reads of both value bytes return 0.
- R2: A write to address 1 (high byte) loads only the staging byte. It changes neither `cmp_value` nor the value returned by reads of addresses 0 and 1.
- R3: In unbuffered modes (mode codes 0 normal, 1 clear-on-match, and the unused codes 4 to 7), a write of byte D to address 0 sets `cmp_value` to {staging byte, D} on the next edge. The same value is also loaded into the shadow buffer.
- R4: In buffered modes (code 2 update-at-TOP, code 3 update-at-BOTTOM), a write to address 0 loads {staging byte, D} into the shadow buffer and leaves `cmp_value` unchanged. Reads of addresses 0 and 1 return the buffer's low byte and high byte.
- R5: In mode 2, a cycle with `top_stb` high copies the buffer into `cmp_value` on that edge. `bot_stb` has no effect in this mode.
- R6: In mode 3, a cycle with `bot_stb` high copies the buffer into `cmp_value` on that edge. `top_stb` has no effect in this mode.
- R7: On the first cycle in an unbuffered mode after a buffered mode, the buffer is copied into `cmp_value`. If that same cycle carries a low-byte write, the written value takes its place.
- R8: If `count` equals `cmp_value` in a cycle, `match_flag` is 1 after that edge.
- R9: `match_flag` stays set until a write to address 2 with data bit 0 equal to 1 clears it. A write there with bit 0 equal to 0 has no effect.
- R10: A match in the same cycle as a clear write leaves `match_flag` set.
- R11: A cycle with `rd_en` high loads `rd_data` on that edge with the addressed byte: address 0 low byte, address 1 high byte, address 2 the flag in bit 0, address 3 zero. In other cycles `rd_data` holds its value.
- R12: The staging byte persists after a low-byte write, so a second low-byte write reuses the same upper byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Waveform mode code |
| top_stb | input | 1 | One-cycle counter TOP event |
| bot_stb | input | 1 | One-cycle counter BOTTOM event |
| count | input | 16 | Current counter value |
| addr | input | 2 | Register address: 0 low, 1 high, 2 flag |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Registered read data byte |
| cmp_value | output | 16 | Live compare register |
| match_flag | output | 1 | Sticky compare-match flag |

## Verification
Every result is due exactly one rising edge after its cause. A low-byte write, an update strobe or a mode exit shows on `cmp_value` one edge later. A counter hit shows on `match_flag` one edge later, and a read strobe shows on `rd_data` one edge later. The bench drives each cycle's inputs on the falling edge and advances its own reference state across the following rising edge. It compares all three outputs on the next falling edge, so every comparison falls in the cycle the result is due. Strobes and writes are never double-counted.

// File: rtl/cmp16_pkg.sv
package cmp16_pkg;

    localparam logic [2:0] MODE_FREE    = 3'd0;
    localparam logic [2:0] MODE_CLR     = 3'd1;
    localparam logic [2:0] MODE_PWM_TOP = 3'd2;
    localparam logic [2:0] MODE_PWM_BOT = 3'd3;

    localparam logic [1:0] ADR_LO   = 2'd0;
    localparam logic [1:0] ADR_HI   = 2'd1;
    localparam logic [1:0] ADR_FLAG = 2'd2;

    function automatic logic is_buffered(input logic [2:0] m);
        return (m == MODE_PWM_TOP) || (m == MODE_PWM_BOT);
    endfunction

endpackage

// File: rtl/cmp16_regs.sv
module cmp16_regs
    import cmp16_pkg::*;
#(
    parameter int BUS_W = 8,
    localparam int VAL_W = 2 * BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode,
    input  logic             top_stb,
    input  logic             bot_stb,
    input  logic [1:0]       addr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [BUS_W-1:0] wr_data,
    input  logic             flag_in,
    output logic [BUS_W-1:0] rd_data,
    output logic [VAL_W-1:0] act_value
);

    typedef struct packed {
        logic [BUS_W-1:0] stage;
        logic [VAL_W-1:0] shadow;
        logic [VAL_W-1:0] act;
        logic             was_buf;
        logic [BUS_W-1:0] rd;
    } regs_t;

    regs_t r_d, r_q;

    logic             buffered;
    logic             lo_wr;
    logic             hi_wr;
    logic             upd;
    logic             leave;
    logic [VAL_W-1:0] commit_val;
    logic [VAL_W-1:0] view;

    always_comb begin
        buffered   = is_buffered(mode);
        lo_wr      = wr_en && (addr == ADR_LO);
        hi_wr      = wr_en && (addr == ADR_HI);
        upd        = ((mode == MODE_PWM_TOP) && top_stb) ||
                     ((mode == MODE_PWM_BOT) && bot_stb);
        leave      = r_q.was_buf && !buffered;
        commit_val = {r_q.stage, wr_data};
        view       = buffered ? r_q.shadow : r_q.act;

        r_d         = r_q;
        r_d.was_buf = buffered;

        if (hi_wr) begin
            r_d.stage = wr_data;
        end
        if (lo_wr) begin
            r_d.shadow = commit_val;
        end
        if (upd || leave) begin
            r_d.act = r_q.shadow;
        end
        if (lo_wr && !buffered) begin
            r_d.act = commit_val;
        end

        if (rd_en) begin
            case (addr)
                ADR_LO:   r_d.rd = view[BUS_W-1:0];
                ADR_HI:   r_d.rd = view[VAL_W-1:BUS_W];
                ADR_FLAG: r_d.rd = {{(BUS_W-1){1'b0}}, flag_in};
                default:  r_d.rd = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_data   = r_q.rd;
    assign act_value = r_q.act;

    p_hi_only_stage_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_wr && !upd && !leave) |=> ($stable(r_q.act) && $stable(r_q.shadow)));

    p_direct_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr && !buffered) |=> (r_q.act == {$past(r_q.stage), $past(wr_data)}));

    p_buffered_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr && buffered && !upd) |=> $stable(r_q.act));

    p_top_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_PWM_TOP) && top_stb) |=> (r_q.act == $past(r_q.shadow)));

    p_bot_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_PWM_BOT) && bot_stb) |=> (r_q.act == $past(r_q.shadow)));

    p_exit_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (leave && !lo_wr) |=> (r_q.act == $past(r_q.shadow)));

    p_read_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(r_q.rd));

endmodule

// File: rtl/cmp16_match.sv
module cmp16_match #(
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VAL_W-1:0] count,
    input  logic [VAL_W-1:0] cmp_value,
    input  logic             clr,
    output logic             flag
);

    typedef struct packed {
        logic flag;
    } match_t;

    match_t m_d, m_q;
    logic   hit;

    always_comb begin
        hit = (count == cmp_value);
        m_d = m_q;
        if (hit) begin
            m_d.flag = 1'b1;
        end else if (clr) begin
            m_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign flag = m_q.flag;

    p_hit_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (count == cmp_value) |=> flag);

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (count != cmp_value)) |=> !flag);

    p_hit_beats_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (count == cmp_value)) |=> flag);

endmodule

// File: rtl/cmp16_dbuf.sv
module cmp16_dbuf
    import cmp16_pkg::*;
#(
    parameter int BUS_W = 8,
    localparam int VAL_W = 2 * BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode,
    input  logic             top_stb,
    input  logic             bot_stb,
    input  logic [VAL_W-1:0] count,
    input  logic [1:0]       addr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [BUS_W-1:0] wr_data,
    output logic [BUS_W-1:0] rd_data,
    output logic [VAL_W-1:0] cmp_value,
    output logic             match_flag
);

    logic flag_clr;

    assign flag_clr = wr_en && (addr == ADR_FLAG) && wr_data[0];

    cmp16_regs #(.BUS_W(BUS_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .top_stb   (top_stb),
        .bot_stb   (bot_stb),
        .addr      (addr),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wr_data   (wr_data),
        .flag_in   (match_flag),
        .rd_data   (rd_data),
        .act_value (cmp_value)
    );

    cmp16_match #(.VAL_W(VAL_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .count     (count),
        .cmp_value (cmp_value),
        .clr       (flag_clr),
        .flag      (match_flag)
    );

endmodule

// File: tb/sim_cmp16_dbuf.sv
module sim_cmp16_dbuf;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic        top_stb = 1'b0;
    logic        bot_stb = 1'b0;
    logic [15:0] count = 16'hFFFE;
    logic [1:0]  addr = 2'd0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wr_data = 8'd0;
    logic [7:0]  rd_data;
    logic [15:0] cmp_value;
    logic        match_flag;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference state
    logic [7:0]  m_stage = '0;
    logic [15:0] m_buf = '0;
    logic [15:0] m_act = '0;
    logic        m_flag = 1'b0;
    logic        m_wasbuf = 1'b0;
    logic [7:0]  m_rd = '0;

    always #2 clk = ~clk;

    cmp16_dbuf u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .top_stb(top_stb),
        .bot_stb(bot_stb), .count(count), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data),
        .cmp_value(cmp_value), .match_flag(match_flag)
    );

    function automatic logic buffered_mode(input logic [2:0] m);
        return (m == 3'd2) || (m == 3'd3);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic [2:0] md, input logic t, input logic b,
                       input logic [15:0] c, input logic [1:0] a, input logic w,
                       input logic r, input logic [7:0] d);
        logic        bm, lo, hi, up, lv, clr, hit;
        logic [15:0] tgt, view;
        logic [7:0]  n_stage, n_rd;
        logic [15:0] n_buf, n_act;
        logic        n_flag;
        string       atag, ftag;
        mode = md; top_stb = t; bot_stb = b; count = c;
        addr = a; wr_en = w; rd_en = r; wr_data = d;
        bm  = buffered_mode(md);
        lo  = w && (a == 2'd0);
        hi  = w && (a == 2'd1);
        up  = ((md == 3'd2) && t) || ((md == 3'd3) && b);
        lv  = m_wasbuf && !bm;
        clr = w && (a == 2'd2) && d[0];
        hit = (c == m_act);
        tgt = {m_stage, d};
        view = bm ? m_buf : m_act;
        n_stage = hi ? d : m_stage;
        n_buf = lo ? tgt : m_buf;
        n_act = m_act;
        atag = "R12";
        if (hi) atag = "R2";
        if (lo && bm) atag = "R4";
        if (up || lv) begin
            n_act = m_buf;
            atag = lv ? "R7" : ((md == 3'd2) ? "R5" : "R6");
        end
        if (lo && !bm) begin
            n_act = tgt;
            atag = "R3";
        end
        n_flag = hit ? 1'b1 : (clr ? 1'b0 : m_flag);
        ftag = (hit && clr) ? "R10" : (hit ? "R8" : "R9");
        n_rd = m_rd;
        if (r) begin
            case (a)
                2'd0: n_rd = view[7:0];
                2'd1: n_rd = view[15:8];
                2'd2: n_rd = {7'd0, m_flag};
                default: n_rd = 8'd0;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        m_stage = n_stage; m_buf = n_buf; m_act = n_act;
        m_flag = n_flag; m_wasbuf = bm; m_rd = n_rd;
        chk(atag, 32'(cmp_value), 32'(m_act));
        chk(ftag, 32'(match_flag), 32'(m_flag));
        chk("R11", 32'(rd_data), 32'(m_rd));
    endtask

    task automatic idle(input logic [2:0] md);
        cyc(md, 1'b0, 1'b0, 16'hFFFE, 2'd0, 1'b0, 1'b0, 8'd0);
    endtask

    task automatic wr(input logic [2:0] md, input logic [1:0] a, input logic [7:0] d);
        cyc(md, 1'b0, 1'b0, 16'hFFFE, a, 1'b1, 1'b0, d);
    endtask

    task automatic rd(input logic [2:0] md, input logic [1:0] a);
        cyc(md, 1'b0, 1'b0, 16'hFFFE, a, 1'b0, 1'b1, 8'd0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5A17);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", 32'(cmp_value), 32'h0);
        chk("R1", 32'(match_flag), 32'h0);
        chk("R1", 32'(rd_data), 32'h0);
        rd(3'd0, 2'd0);
        chk("R1", 32'(rd_data), 32'h0);
        rd(3'd0, 2'd1);
        chk("R1", 32'(rd_data), 32'h0);

        // R2: staging byte only
        wr(3'd0, 2'd1, 8'h12);
        chk("R2", 32'(cmp_value), 32'h0);
        rd(3'd0, 2'd1);
        chk("R2", 32'(rd_data), 32'h0);
        // R3: direct commit
        wr(3'd0, 2'd0, 8'h34);
        chk("R3", 32'(cmp_value), 32'h1234);
        // R12: staged byte reused
        wr(3'd1, 2'd0, 8'h56);
        chk("R12", 32'(cmp_value), 32'h1256);

        // R4: buffered write in mode 2
        idle(3'd2);
        wr(3'd2, 2'd1, 8'hAB);
        wr(3'd2, 2'd0, 8'hCD);
        chk("R4", 32'(cmp_value), 32'h1256);
        rd(3'd2, 2'd0);
        chk("R4", 32'(rd_data), 32'hCD);
        // R5: bottom ignored, top loads
        cyc(3'd2, 1'b0, 1'b1, 16'hFFFE, 2'd0, 1'b0, 1'b0, 8'd0);
        chk("R5", 32'(cmp_value), 32'h1256);
        cyc(3'd2, 1'b1, 1'b0, 16'hFFFE, 2'd0, 1'b0, 1'b0, 8'd0);
        chk("R5", 32'(cmp_value), 32'hABCD);

        // R6: mode 3
        wr(3'd3, 2'd1, 8'h01);
        wr(3'd3, 2'd0, 8'h02);
        cyc(3'd3, 1'b1, 1'b0, 16'hFFFE, 2'd0, 1'b0, 1'b0, 8'd0);
        chk("R6", 32'(cmp_value), 32'hABCD);
        cyc(3'd3, 1'b0, 1'b1, 16'hFFFE, 2'd0, 1'b0, 1'b0, 8'd0);
        chk("R6", 32'(cmp_value), 32'h0102);

        // R7: leave buffered mode with a pending value
        wr(3'd3, 2'd1, 8'h77);
        wr(3'd3, 2'd0, 8'h77);
        chk("R7", 32'(cmp_value), 32'h0102);
        idle(3'd1);
        chk("R7", 32'(cmp_value), 32'h7777);

        // R8, R9, R10: flag
        cyc(3'd1, 1'b0, 1'b0, 16'h7777, 2'd0, 1'b0, 1'b0, 8'd0);
        chk("R8", 32'(match_flag), 32'h1);
        idle(3'd1);
        idle(3'd1);
        chk("R9", 32'(match_flag), 32'h1);
        wr(3'd1, 2'd2, 8'hFE);
        chk("R9", 32'(match_flag), 32'h1);
        rd(3'd1, 2'd2);
        chk("R11", 32'(rd_data), 32'h01);
        wr(3'd1, 2'd2, 8'h01);
        chk("R9", 32'(match_flag), 32'h0);
        cyc(3'd1, 1'b0, 1'b0, 16'h7777, 2'd2, 1'b1, 1'b0, 8'h01);
        chk("R10", 32'(match_flag), 32'h1);
        rd(3'd1, 2'd3);
        chk("R11", 32'(rd_data), 32'h00);

        // random phase
        begin
            logic [2:0] md;
            md = 3'd2;
            for (int i = 0; i < 4000; i++) begin
                logic [15:0] c;
                if (($urandom % 16) == 0) md = 3'($urandom % 8);
                c = (($urandom % 4) == 0) ? m_act : 16'($urandom);
                cyc(md, (($urandom % 8) == 0), (($urandom % 8) == 0), c,
                    2'($urandom % 4), (($urandom % 3) == 0),
                    (($urandom % 3) == 0), 8'($urandom));
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule